// File: doc/BRIEF.md
# Sleep Wakeup and Buzz Sequencer

This block paces the power-up steps that bring a sleeping device back to full operation. It also paces a short periodic "buzz" that briefly powers the supply supervisor while the device sleeps. All timing is counted in ticks of a 1 MHz enable (`tickEn`), so one tick is one microsecond.

A full wakeup walks through phases T0, T1 and T2 and ends in the awake state. A buzz walks through T0 and T1 only and then returns to sleep. Each phase length comes from its own non-uniform table of four taps. One configuration bit doubles every phase.

A buzz scheduler counts ticks while the device sleeps and launches a buzz when the selected interval expires. The interval is one of two fixed long periods or a caller-supplied period. The oscillator-off bit stops the scheduler and the sleep-timer wake. With the oscillator off and the bus-standby bit clear, the device is in its deepest sleep and only the GPIO wake can start a wakeup. At power-up, system software normally loads the tap configuration with 7F (hex): the longest taps in every phase, with doubling on.

Top module: `sleep_wake_sequencer`

## Requirements
- R1: After reset, `awake`=1, `regEn`=1, and `phaseStb`, `wakeDone` and `buzzDone` are 0.
- R2: A `sleepReq` sampled while awake moves the block to sleep on that edge (`awake`=0, `regEn`=0). A `sleepReq` during a wakeup or buzz sequence is ignored, and that sequence completes.
- R3: Phase T0 lasts 10, 14, 20 or 30 ticks for `tapCfg[1:0]` = 00, 01, 10, 11. `phaseStb[0]` pulses for one cycle after its last tick.
- R4: Phase T1 lasts 3, 4, 5 or 10 ticks for `tapCfg[3:2]` = 00, 01, 10, 11. `phaseStb[1]` pulses after its last tick.
- R5: Phase T2 lasts 1, 2, 5 or 10 ticks for `tapCfg[5:4]` = 00, 01, 10, 11. `phaseStb[2]` and `wakeDone` pulse together after its last tick, and `awake` is 1 from that cycle on.
- R6: When `tapCfg[6]` is 1, every phase lasts twice its table value.
- R7: Phases advance only on cycles with `tickEn`=1. Cycles without a tick leave the remaining time unchanged.
- R8: A buzz runs T0 then T1 with `regEn`=1 and never runs T2. `buzzDone` pulses together with `phaseStb[1]`, and the block is then back in sleep.
- R9: In sleep, a buzz starts after an interval of ticks selected by `sleepCfg[3:2]`: 01 gives 32768, 10 gives 8192, and 00 or 11 gives `compatPeriod`. The interval restarts on sleep entry and after each buzz.
- R10: With `sleepCfg[0]`=1 (oscillator off), no buzz starts and `timerWake` is ignored.
- R11: `gpioWake` always starts a wakeup from sleep. `i2cWake` does so only when `sleepCfg[1]`=1. With `sleepCfg[0]`=1 and `sleepCfg[1]`=0, only `gpioWake` can leave sleep.
- R12: A wake request is accepted during a buzz, including in the cycle of its last tick. It is held, and when the buzz finishes a full wakeup follows without returning to sleep. A wake in the same cycle that the buzz interval expires wins, and no buzz runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | 1 MHz tick enable |
| sleepReq | input | 1 | Request to enter sleep |
| gpioWake | input | 1 | GPIO wake event |
| timerWake | input | 1 | Sleep-timer wake event |
| i2cWake | input | 1 | Bus-address wake event |
| tapCfg | input | 7 | [1:0] T0 tap, [3:2] T1 tap, [5:4] T2 tap, [6] double |
| sleepCfg | input | 4 | [0] oscillator off, [1] bus standby, [3:2] buzz rate |
| compatPeriod | input | 16 | Buzz interval in ticks for rate 00/11 (at least 1) |
| phaseStb | output | 3 | End-of-phase strobes for T0, T1, T2 |
| regEn | output | 1 | Regulator/oscillator enable, low only in sleep |
| awake | output | 1 | Device fully awake |
| wakeDone | output | 1 | Wakeup sequence finished (one cycle) |
| buzzDone | output | 1 | Buzz sequence finished (one cycle) |

## Verification
The two functions that can coincide are the buzz scheduler and the wake path. A wake can arrive in the cycle in which the buzz interval expires, or in the cycle of the final tick of a buzz. Both collisions are provoked with the tick held on every cycle, so the bench can place the GPIO pulse on the exact expiring tick or last buzz tick. The outcome is judged at the ports. When the wake meets the expiring interval, no `buzzDone` pulse appears and a full T0/T1/T2 wakeup with `wakeDone` follows. When the wake meets the last buzz tick, `buzzDone` pulses with `regEn` still high and a wakeup follows directly.

// File: rtl/sleepseq_pkg.sv
package sleepseq_pkg;

  typedef enum logic [2:0] {
    ST_AWAKE,
    ST_SLEEP,
    ST_WT0,
    ST_WT1,
    ST_WT2,
    ST_BT0,
    ST_BT1
  } seqState_t;

  typedef enum logic [1:0] {
    PH_T0,
    PH_T1,
    PH_T2
  } phaseSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;     // load phase counter with the duration of sel
    phaseSel_t sel;      // phase whose duration is loaded
    logic      buzzRun;  // buzz interval counter advances on ticks
    logic      buzzClr;  // buzz interval counter restarts
  } seqCtrl_t;

endpackage

// File: rtl/sleepseq_datapath.sv
module sleepseq_datapath
  import sleepseq_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int BUZZ_W      = 16,
  parameter int SLOW_PERIOD = 32768,
  parameter int FAST_PERIOD = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  seqCtrl_t          ctrl,
  input  logic              dblTaps,
  input  logic [1:0]        t0Code,
  input  logic [1:0]        t1Code,
  input  logic [1:0]        t2Code,
  input  logic [1:0]        buzzRate,
  input  logic [BUZZ_W-1:0] compatPeriod,
  output logic              phaseLast,
  output logic              buzzDue
);

  localparam logic [BUZZ_W-1:0] SLOW_LEN = BUZZ_W'(SLOW_PERIOD);
  localparam logic [BUZZ_W-1:0] FAST_LEN = BUZZ_W'(FAST_PERIOD);
  localparam logic [CNT_W-1:0]  MAX_LEN  = CNT_W'(60);

  function automatic logic [CNT_W-1:0] phaseLen(phaseSel_t s, logic [1:0] c, logic dbl);
    logic [CNT_W-1:0] base;
    case (s)
      PH_T0: case (c)
        2'b00:   base = CNT_W'(10);
        2'b01:   base = CNT_W'(14);
        2'b10:   base = CNT_W'(20);
        default: base = CNT_W'(30);
      endcase
      PH_T1: case (c)
        2'b00:   base = CNT_W'(3);
        2'b01:   base = CNT_W'(4);
        2'b10:   base = CNT_W'(5);
        default: base = CNT_W'(10);
      endcase
      default: case (c)
        2'b00:   base = CNT_W'(1);
        2'b01:   base = CNT_W'(2);
        2'b10:   base = CNT_W'(5);
        default: base = CNT_W'(10);
      endcase
    endcase
    return dbl ? (base << 1) : base;
  endfunction

  logic [1:0]        selCode;
  logic [CNT_W-1:0]  loadVal;
  logic [CNT_W-1:0]  phaseCnt;
  logic [BUZZ_W-1:0] period;
  logic [BUZZ_W-1:0] buzzCnt;
  logic              buzzHit;

  always_comb begin
    case (ctrl.sel)
      PH_T0:   selCode = t0Code;
      PH_T1:   selCode = t1Code;
      default: selCode = t2Code;
    endcase
    loadVal = phaseLen(ctrl.sel, selCode, dblTaps);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                           phaseCnt <= '0;
    else if (ctrl.load)                  phaseCnt <= loadVal;
    else if (tickEn && phaseCnt != '0)   phaseCnt <= phaseCnt - 1'b1;
  end

  assign phaseLast = tickEn && (phaseCnt == CNT_W'(1));

  always_comb begin
    case (buzzRate)
      2'b01:   period = SLOW_LEN;
      2'b10:   period = FAST_LEN;
      default: period = compatPeriod;
    endcase
  end

  assign buzzHit = (buzzCnt == period - 1'b1);
  assign buzzDue = ctrl.buzzRun && tickEn && buzzHit;

  always_ff @(posedge clk) begin
    if (!rstN)                         buzzCnt <= '0;
    else if (ctrl.buzzClr)             buzzCnt <= '0;
    else if (ctrl.buzzRun && tickEn)   buzzCnt <= buzzHit ? '0 : buzzCnt + 1'b1;
  end

  // a freshly loaded phase always has time left
  assert_load_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> phaseCnt != '0);

  // doubled longest tap is the ceiling
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt <= MAX_LEN);

  // without a tick the remaining time holds
  assert_no_tick_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !ctrl.load) |=> $stable(phaseCnt));

  // interval counter frozen whenever the scheduler is stopped
  assert_buzz_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.buzzRun && !ctrl.buzzClr) |=> $stable(buzzCnt));

endmodule

// File: rtl/sleepseq_control.sv
module sleepseq_control
  import sleepseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       gpioWake,
  input  logic       timerWake,
  input  logic       i2cWake,
  input  logic       oscOff,
  input  logic       i2cOn,
  input  logic       phaseLast,
  input  logic       buzzDue,
  output seqCtrl_t   ctrl,
  output logic [2:0] phaseStb,
  output logic       wakeDone,
  output logic       buzzDone,
  output logic       awake,
  output logic       regEn
);

  seqState_t state, stateN;
  logic [2:0] stbN;
  logic       wakeDoneN, buzzDoneN;
  logic       pend, pendN;
  logic       wakeOk;
  logic       inBuzz;

  assign wakeOk = gpioWake | (timerWake & ~oscOff) | (i2cWake & i2cOn);
  assign inBuzz = (state == ST_BT0) || (state == ST_BT1);

  always_comb begin
    stateN       = state;
    stbN         = '0;
    wakeDoneN    = 1'b0;
    buzzDoneN    = 1'b0;
    ctrl.load    = 1'b0;
    ctrl.sel     = PH_T0;
    ctrl.buzzRun = (state == ST_SLEEP) && !oscOff;
    ctrl.buzzClr = 1'b0;
    case (state)
      ST_AWAKE: if (sleepReq) begin
        stateN       = ST_SLEEP;
        ctrl.buzzClr = 1'b1;
      end
      ST_SLEEP: if (wakeOk) begin
        stateN    = ST_WT0;
        ctrl.load = 1'b1;
      end else if (buzzDue) begin
        stateN    = ST_BT0;
        ctrl.load = 1'b1;
      end
      ST_WT0: if (phaseLast) begin
        stateN    = ST_WT1;
        stbN[0]   = 1'b1;
        ctrl.load = 1'b1;
        ctrl.sel  = PH_T1;
      end
      ST_WT1: if (phaseLast) begin
        stateN    = ST_WT2;
        stbN[1]   = 1'b1;
        ctrl.load = 1'b1;
        ctrl.sel  = PH_T2;
      end
      ST_WT2: if (phaseLast) begin
        stateN    = ST_AWAKE;
        stbN[2]   = 1'b1;
        wakeDoneN = 1'b1;
      end
      ST_BT0: if (phaseLast) begin
        stateN    = ST_BT1;
        stbN[0]   = 1'b1;
        ctrl.load = 1'b1;
        ctrl.sel  = PH_T1;
      end
      ST_BT1: if (phaseLast) begin
        stbN[1]   = 1'b1;
        buzzDoneN = 1'b1;
        if (pend || wakeOk) begin
          stateN    = ST_WT0;
          ctrl.load = 1'b1;
        end else begin
          stateN    = ST_SLEEP;
        end
      end
      default: stateN = ST_AWAKE;
    endcase
  end

  assign pendN = inBuzz && ((stateN == ST_BT0) || (stateN == ST_BT1)) && (pend || wakeOk);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_AWAKE;
      phaseStb <= '0;
      wakeDone <= 1'b0;
      buzzDone <= 1'b0;
      pend     <= 1'b0;
    end else begin
      state    <= stateN;
      phaseStb <= stbN;
      wakeDone <= wakeDoneN;
      buzzDone <= buzzDoneN;
      pend     <= pendN;
    end
  end

  assign awake = (state == ST_AWAKE);
  assign regEn = (state != ST_SLEEP);

  // a buzz never produces the third strobe
  assert_buzz_no_t2_R8: assert property (@(posedge clk) disable iff (!rstN)
    inBuzz |=> !phaseStb[2]);

  // completion of wakeup coincides with the last phase strobe and full power
  assert_wake_done_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    wakeDone |-> (phaseStb[2] && awake));

  // sleeping with the oscillator off never enters a buzz
  assert_osc_off_no_buzz_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SLEEP) && oscOff) |=> (state != ST_BT0));

  // deepest sleep leaves only on a GPIO wake
  assert_deep_gpio_only_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SLEEP) && oscOff && !i2cOn && !gpioWake) |=> (state == ST_SLEEP));

  // a held wake turns the end of a buzz into a wakeup
  assert_pending_wake_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_BT1) && phaseLast && pend) |=> (state == ST_WT0));

  // sleep request has no effect once a sequence runs
  assert_sleep_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WT1) && sleepReq) |=> (state != ST_SLEEP));

endmodule

// File: rtl/sleep_wake_sequencer.sv
module sleep_wake_sequencer
  import sleepseq_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int BUZZ_W      = 16,
  parameter int SLOW_PERIOD = 32768,
  parameter int FAST_PERIOD = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              sleepReq,
  input  logic              gpioWake,
  input  logic              timerWake,
  input  logic              i2cWake,
  input  logic [6:0]        tapCfg,
  input  logic [3:0]        sleepCfg,
  input  logic [BUZZ_W-1:0] compatPeriod,
  output logic [2:0]        phaseStb,
  output logic              regEn,
  output logic              awake,
  output logic              wakeDone,
  output logic              buzzDone
);

  seqCtrl_t ctrl;
  logic     phaseLast;
  logic     buzzDue;

  sleepseq_control ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .sleepReq  (sleepReq),
    .gpioWake  (gpioWake),
    .timerWake (timerWake),
    .i2cWake   (i2cWake),
    .oscOff    (sleepCfg[0]),
    .i2cOn     (sleepCfg[1]),
    .phaseLast (phaseLast),
    .buzzDue   (buzzDue),
    .ctrl      (ctrl),
    .phaseStb  (phaseStb),
    .wakeDone  (wakeDone),
    .buzzDone  (buzzDone),
    .awake     (awake),
    .regEn     (regEn)
  );

  sleepseq_datapath #(
    .CNT_W       (CNT_W),
    .BUZZ_W      (BUZZ_W),
    .SLOW_PERIOD (SLOW_PERIOD),
    .FAST_PERIOD (FAST_PERIOD)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .tickEn       (tickEn),
    .ctrl         (ctrl),
    .dblTaps      (tapCfg[6]),
    .t0Code       (tapCfg[1:0]),
    .t1Code       (tapCfg[3:2]),
    .t2Code       (tapCfg[5:4]),
    .buzzRate     (sleepCfg[3:2]),
    .compatPeriod (compatPeriod),
    .phaseLast    (phaseLast),
    .buzzDue      (buzzDue)
  );

endmodule

// File: tb/sleep_wake_sequencer_tb.sv
module sleep_wake_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rstN, tickEn, sleepReq, gpioWake, timerWake, i2cWake;
  logic [6:0]  tapCfg;
  logic [3:0]  sleepCfg;
  logic [15:0] compatPeriod;
  logic [2:0]  phaseStb;
  logic        regEn, awake, wakeDone, buzzDone;

  int vecs = 0;
  int miss = 0;
  int tickPct = 100;
  bit finished = 0;

  always #2 clk = ~clk;

  sleep_wake_sequencer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sleepReq(sleepReq),
    .gpioWake(gpioWake), .timerWake(timerWake), .i2cWake(i2cWake),
    .tapCfg(tapCfg), .sleepCfg(sleepCfg), .compatPeriod(compatPeriod),
    .phaseStb(phaseStb), .regEn(regEn), .awake(awake),
    .wakeDone(wakeDone), .buzzDone(buzzDone)
  );

  function automatic int lenT0(logic [1:0] c, bit dbl);
    int b;
    case (c) 2'd0: b = 10; 2'd1: b = 14; 2'd2: b = 20; default: b = 30; endcase
    return dbl ? 2 * b : b;
  endfunction
  function automatic int lenT1(logic [1:0] c, bit dbl);
    int b;
    case (c) 2'd0: b = 3; 2'd1: b = 4; 2'd2: b = 5; default: b = 10; endcase
    return dbl ? 2 * b : b;
  endfunction
  function automatic int lenT2(logic [1:0] c, bit dbl);
    int b;
    case (c) 2'd0: b = 1; 2'd1: b = 2; 2'd2: b = 5; default: b = 10; endcase
    return dbl ? 2 * b : b;
  endfunction

  task automatic check(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock with a random tick; called and returns at a falling edge
  task automatic cyc(output bit ticked);
    tickEn = ($urandom_range(99) < tickPct);
    @(posedge clk);
    ticked = tickEn;
    @(negedge clk);
  endtask

  task automatic cycNT();
    tickEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic waitStb(int idx, output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      bit t;
      cyc(t);
      if (t) n++;
      if (phaseStb[idx]) return;
    end
    n = -1;
  endtask

  task automatic waitRegEn(int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      bit t;
      cyc(t);
      if (t) n++;
      if (regEn) return;
    end
    n = -1;
  endtask

  task automatic enterSleep();
    sleepReq = 1'b1;
    cycNT();
    sleepReq = 1'b0;
    check("R2 awake after sleepReq", awake, 0);
    check("R2 regEn after sleepReq", regEn, 0);
  endtask

  task automatic wakeGpio();
    gpioWake = 1'b1;
    cycNT();
    gpioWake = 1'b0;
  endtask

  // full wakeup from the moment the sequence has been entered
  task automatic runWakeup(string req);
    int n;
    bit d = tapCfg[6];
    waitStb(0, n); check({req, " R3/R6 T0 ticks"}, n, lenT0(tapCfg[1:0], d));
    waitStb(1, n); check({req, " R4/R6 T1 ticks"}, n, lenT1(tapCfg[3:2], d));
    waitStb(2, n); check({req, " R5/R6 T2 ticks"}, n, lenT2(tapCfg[5:4], d));
    check({req, " R5 wakeDone"}, wakeDone, 1);
    check({req, " R5 awake"}, awake, 1);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      miss++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    int n;
    bit t;
    void'($urandom(32'h5eed_0421));
    rstN = 0; tickEn = 0; sleepReq = 0; gpioWake = 0; timerWake = 0; i2cWake = 0;
    tapCfg = 7'h7F; sleepCfg = 4'h0; compatPeriod = 16'd40;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 awake", awake, 1);
    check("R1 regEn", regEn, 1);
    check("R1 phaseStb", phaseStb, 0);
    check("R1 wakeDone", wakeDone, 0);
    check("R1 buzzDone", buzzDone, 0);

    // R3 R4 R5 R6 R7: random taps and random tick density, deepest sleep
    for (int k = 0; k < 14; k++) begin
      tapCfg   = (k == 0) ? 7'h7F : (k == 1) ? 7'h00 : 7'($urandom);
      tickPct  = 30 + $urandom_range(70);
      sleepCfg = 4'b0101;
      enterSleep();
      wakeGpio();
      check("R11 gpio leaves deepest sleep", regEn, 1);
      runWakeup("rand");
    end

    // R7: no tick, no progress; R2: sleepReq ignored mid-sequence
    tapCfg = 7'h00; tickPct = 100;
    enterSleep();
    wakeGpio();
    repeat (50) cycNT();
    check("R7 no strobe without ticks", phaseStb, 0);
    waitStb(0, n); check("R7 T0 after idle", n, 10);
    sleepReq = 1'b1; cyc(t); sleepReq = 1'b0;
    check("R2 sleepReq ignored in sequence", regEn, 1);
    waitStb(1, n); check("R2 T1 completes", n, 3 - 1);
    waitStb(2, n); check("R2 wakeDone after ignored sleepReq", wakeDone, 1);

    // R8 R9: compat buzz, twice, with random ticks
    tapCfg = 7'h1B; compatPeriod = 16'd37; sleepCfg = 4'b0000; tickPct = 60;
    enterSleep();
    for (int r = 0; r < 2; r++) begin
      waitRegEn(2000, n); check("R9 compat interval", n, 37);
      check("R8 buzz not awake", awake, 0);
      waitStb(0, n); check("R8 buzz T0 ticks", n, lenT0(2'b11, 0));
      waitStb(1, n); check("R8 buzz T1 ticks", n, lenT1(2'b10, 0));
      check("R8 buzzDone", buzzDone, 1);
      check("R8 no T2 strobe", phaseStb[2], 0);
      check("R8 back to sleep", regEn, 0);
    end
    // R9: reserved code behaves as compat
    sleepCfg = 4'b1100; compatPeriod = 16'd21;
    waitRegEn(2000, n); check("R9 code 11 interval", n, 21);
    waitStb(0, n); waitStb(1, n); check("R8 buzzDone code 11", buzzDone, 1);
    wakeGpio(); runWakeup("R11");

    // R9 slow rate 32768 ticks
    tickPct = 100; sleepCfg = 4'b0100;
    enterSleep();
    waitRegEn(40000, n); check("R9 rate 01 interval", n, 32768);
    waitStb(0, n); waitStb(1, n); check("R8 slow buzzDone", buzzDone, 1);
    // R9 fast rate 8192 with a wake held during the buzz (R12)
    sleepCfg = 4'b1000;
    wakeGpio(); runWakeup("R11");
    enterSleep();
    waitRegEn(10000, n); check("R9 rate 10 interval", n, 8192);
    wakeGpio();
    waitStb(0, n); check("R12 buzz T0 unchanged", n, lenT0(2'b11, 0));
    check("R12 no early buzzDone", buzzDone, 0);
    waitStb(1, n); check("R12 buzzDone with pending", buzzDone, 1);
    check("R12 stays powered", regEn, 1);
    runWakeup("R12 pending");

    // R12: wake on the last tick of a buzz
    sleepCfg = 4'b0000; compatPeriod = 16'd12; tapCfg = 7'h00;
    enterSleep();
    waitRegEn(100, n);
    waitStb(0, n);
    repeat (2) cyc(t);
    gpioWake = 1'b1; cyc(t); gpioWake = 1'b0;
    check("R12 last-tick buzzDone", buzzDone, 1);
    check("R12 last-tick regEn", regEn, 1);
    runWakeup("R12 last tick");

    // R12: wake in the same cycle the interval expires
    enterSleep();
    repeat (11) cyc(t);
    check("R9 still asleep before expiry", regEn, 0);
    gpioWake = 1'b1; cyc(t); gpioWake = 1'b0;
    check("R12 wake wins regEn", regEn, 1);
    waitStb(0, n); check("R12 wake wins T0", n, 10);
    waitStb(1, n); check("R12 wake wins no buzzDone", buzzDone, 0);
    waitStb(2, n); check("R12 wake wins wakeDone", wakeDone, 1);

    // R10 R11: oscillator off, bus standby off: timer and bus wake ignored
    sleepCfg = 4'b0001; compatPeriod = 16'd5;
    enterSleep();
    begin
      int bad = 0;
      for (int i = 0; i < 80; i++) begin
        timerWake = (i % 7 == 3);
        i2cWake   = (i % 11 == 5);
        cyc(t);
        if (regEn || awake) bad++;
      end
      timerWake = 0; i2cWake = 0;
      check("R10 R11 no buzz or wake in deepest sleep", bad, 0);
    end
    // R11: bus standby on allows bus wake
    sleepCfg = 4'b0011;
    i2cWake = 1'b1; cycNT(); i2cWake = 1'b0;
    check("R11 i2c wake accepted", regEn, 1);
    runWakeup("R11 i2c");
    // R10: oscillator off still ignores timer wake with standby on
    enterSleep();
    timerWake = 1'b1; cycNT(); timerWake = 1'b0;
    check("R10 timer wake ignored", regEn, 0);
    // R11: oscillator on allows timer wake
    sleepCfg = 4'b0100;
    timerWake = 1'b1; cycNT(); timerWake = 1'b0;
    check("R11 timer wake accepted", regEn, 1);
    runWakeup("R11 timer");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule